// File: doc/BRIEF.md
# Transaction Error Flagging and Alarm

This block sits beside the receive path of a serial position-encoder link. Upstream detectors report each kind of fault as a single-cycle strobe. The block collects those strobes into a six-bit error register, and that register is cleared when the next transaction starts. The block also counts faulty transactions and raises a sticky alarm once the count goes above a configured limit.

A transaction counts as faulty at most once, however many of its error bits are set. The fault counter stops at its maximum value. An alarm-clear pulse zeroes the counter and drops the alarm together. The running count is available on an output so that the threshold logic can be observed.

Top module: `tfa_fault_monitor`

## Requirements
- R1: Error strobe bit k sets error-flag bit k at the next clock edge. The bit map is: 0 = received control-field parity, 1 = bad start pattern, 2 = incomplete message (timeout), 3 = CRC mismatch, 4 = parity error reported for the transmitted request, 5 = delimiter error reported for the transmitted request.
- R2: Error flags hold their value until a transaction-start pulse arrives. That pulse clears all flags at the next edge. Strobes that arrive in the same cycle as the start pulse belong to the new transaction and appear in the flags.
- R3: The fault count rises by exactly one per faulty transaction, on the first cycle in which any strobe arrives for that transaction. Further bits, or later strobes in the same transaction, do not increment it again.
- R4: The fault count saturates at 2**CNT_W-1 and never wraps.
- R5: `alarm_o` is high exactly when the fault count exceeds FAULT_LIMIT. It rises on the same edge as the count and stays high until an alarm clear.
- R6: An alarm-clear pulse with no fault in the same cycle sets the count to 0 and drops the alarm at the next edge.
- R7: When a clear and a new fault fall in the same cycle, the clear wins and the count restarts at 1. The alarm then follows R5 for that value.
- R8: An active-low reset asynchronously forces the flags, the count and the alarm to zero. Its release is synchronized to the clock.
- R9: An alarm clear leaves the error flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| txn_start_i | input | 1 | One-cycle pulse marking the start of a transaction |
| err_strobe_i | input | 6 | Error strobes, using the bit map in R1 |
| alarm_clr_i | input | 1 | One-cycle alarm and counter clear |
| err_flags_o | output | 6 | Error register for the current transaction |
| fault_count_o | output | CNT_W | Number of faulty transactions (saturating) |
| alarm_o | output | 1 | Sticky fault alarm |

## Verification
The bench builds the block with CNT_W=3 and FAULT_LIMIT=2. With these values, the alarm threshold is crossed after three faulty transactions, and counter saturation at 7 is reached within a few more, so both R4 and R5 are covered in a short run. The small limit also makes the collision case in R7 visible on the alarm: after a collided clear, the count restarts at 1, which stays below the limit, so the alarm must stay low.

// File: rtl/tfa_pkg.sv
package tfa_pkg;
  localparam int unsigned ERR_W = 6;

  typedef logic [ERR_W-1:0] err_vec_t;

  // Bit positions are decoded by downstream logic and stay fixed.
  typedef enum int unsigned {
    EB_CF_PARITY  = 0,
    EB_BAD_START  = 1,
    EB_TIMEOUT    = 2,
    EB_CRC        = 3,
    EB_TX_PARITY  = 4,
    EB_TX_DELIM   = 5
  } err_bit_e;
endpackage

// File: rtl/tfa_rst_sync.sv
module tfa_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/tfa_err_capture.sv
module tfa_err_capture
  import tfa_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  err_vec_t strobe_i,
  output err_vec_t flags_o,
  output logic     fault_evt_o
);
  err_vec_t flags_q, flags_d;
  logic     flags_en;
  logic     txn_clean;

  // A transaction is still clean if it has just started or has no flag yet.
  always_comb begin
    txn_clean   = start_i || (flags_q == '0);
    fault_evt_o = (strobe_i != '0) && txn_clean;
    flags_en    = start_i || (strobe_i != '0);
    flags_d     = (start_i ? '0 : flags_q) | strobe_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flags_q <= '0;
    else if (flags_en) flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/tfa_fault_counter.sv
module tfa_fault_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] count_next_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = clr_i || inc_i;
    if (clr_i) begin
      cnt_d = inc_i ? CNT_ONE : '0;
    end else if (inc_i && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o      = cnt_q;
  assign count_next_o = cnt_d;
endmodule

// File: rtl/tfa_alarm.sv
module tfa_alarm #(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned FAULT_LIMIT = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] count_next_i,
  output logic             alarm_o
);
  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(FAULT_LIMIT);

  logic alarm_q, alarm_d;

  always_comb begin
    alarm_d = (alarm_q && !clr_i) || (count_next_i > LIMIT_V);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) alarm_q <= 1'b0;
    else         alarm_q <= alarm_d;
  end

  assign alarm_o = alarm_q;
endmodule

// File: rtl/tfa_fault_monitor.sv
module tfa_fault_monitor
  import tfa_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned FAULT_LIMIT = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             txn_start_i,
  input  logic [5:0]       err_strobe_i,
  input  logic             alarm_clr_i,
  output logic [5:0]       err_flags_o,
  output logic [CNT_W-1:0] fault_count_o,
  output logic             alarm_o
);
  localparam int unsigned SYNC_STAGES = 2;

  logic             rst_sync_n;
  logic             fault_evt;
  logic [CNT_W-1:0] cnt_next;
  err_vec_t         flags;

  tfa_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  tfa_err_capture u_capture (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .start_i     (txn_start_i),
    .strobe_i    (err_strobe_i),
    .flags_o     (flags),
    .fault_evt_o (fault_evt)
  );

  tfa_fault_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_n),
    .inc_i        (fault_evt),
    .clr_i        (alarm_clr_i),
    .count_o      (fault_count_o),
    .count_next_o (cnt_next)
  );

  tfa_alarm #(.CNT_W(CNT_W), .FAULT_LIMIT(FAULT_LIMIT)) u_alarm (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_n),
    .clr_i        (alarm_clr_i),
    .count_next_i (cnt_next),
    .alarm_o      (alarm_o)
  );

  assign err_flags_o = flags;
endmodule

// File: rtl/tfa_fault_monitor_chk.sv
module tfa_fault_monitor_chk #(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned FAULT_LIMIT = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [5:0]       strobe,
  input logic             clr,
  input logic [5:0]       flags,
  input logic [CNT_W-1:0] count,
  input logic             alarm
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LIM  = CNT_W'(FAULT_LIMIT);

  a_r1_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe != 6'd0) |=> ((flags & $past(strobe)) == $past(strobe)));

  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (start && strobe == 6'd0) |=> (flags == 6'd0));

  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (count == $past(count)) || (count == CNT_W'($past(count) + 1'b1)));

  a_r4_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && count == CMAX) |=> (count == CMAX));

  a_r5_alarm_level: assert property (@(posedge clk) disable iff (!rst_n)
    alarm == (count > LIM));

  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && strobe == 6'd0) |=> (count == '0 && !alarm));

  a_r7_clear_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && start && strobe != 6'd0) |=> (count == CNT_W'(1)));

  a_r9_clear_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !start && strobe == 6'd0) |=> $stable(flags));
endmodule

bind tfa_fault_monitor tfa_fault_monitor_chk #(
  .CNT_W(CNT_W), .FAULT_LIMIT(FAULT_LIMIT)
) u_chk (
  .clk    (clk_i),
  .rst_n  (rst_sync_n),
  .start  (txn_start_i),
  .strobe (err_strobe_i),
  .clr    (alarm_clr_i),
  .flags  (err_flags_o),
  .count  (fault_count_o),
  .alarm  (alarm_o)
);

// File: tb/tb_tfa_fault_monitor.sv
module tb_tfa_fault_monitor;
  localparam int unsigned CW  = 3;
  localparam int unsigned LIM = 2;
  localparam int unsigned MAXC = (1 << CW) - 1;

  typedef struct packed {
    logic [5:0]    flags;
    logic [CW-1:0] cnt;
    logic          alarm;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [5:0]    strb;
  logic          clr;
  logic [5:0]    flags;
  logic [CW-1:0] cnt;
  logic          alarm;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  exp_t  expq[$];
  string tagq[$];

  logic [5:0]    m_flags = '0;
  int unsigned   m_cnt   = 0;
  logic          m_alarm = 1'b0;

  always #5 clk = ~clk;

  tfa_fault_monitor #(.CNT_W(CW), .FAULT_LIMIT(LIM)) dut (
    .clk_i(clk), .rst_ni(rst_n), .txn_start_i(start), .err_strobe_i(strb),
    .alarm_clr_i(clr), .err_flags_o(flags), .fault_count_o(cnt), .alarm_o(alarm)
  );

  task automatic compare(string tag, exp_t e);
    checks++;
    if (flags !== e.flags || cnt !== e.cnt || alarm !== e.alarm) begin
      fails++;
      $display("FAIL %s: actual flags=%h cnt=%0d alarm=%b expected flags=%h cnt=%0d alarm=%b",
               tag, flags, cnt, alarm, e.flags, e.cnt, e.alarm);
    end
  endtask

  // Monitor: pops one expected item per clock once results settle.
  always @(posedge clk) begin
    #1;
    if (expq.size() > 0) compare(tagq.pop_front(), expq.pop_front());
  end

  // Driver: applies one cycle of stimulus and pushes the predicted result.
  task automatic step(bit s, logic [5:0] e, bit c, string tag);
    bit fault;
    @(negedge clk);
    start = s; strb = e; clr = c;
    fault = (e != 6'd0) && (s || m_flags == 6'd0);
    m_flags = (s ? 6'd0 : m_flags) | e;
    if (c) begin
      m_cnt   = fault ? 1 : 0;
      m_alarm = 1'b0;
    end else if (fault && m_cnt < MAXC) begin
      m_cnt++;
    end
    if (m_cnt > LIM) m_alarm = 1'b1;
    expq.push_back('{flags: m_flags, cnt: CW'(m_cnt), alarm: m_alarm});
    tagq.push_back(tag);
  endtask

  task automatic idle(string tag);
    step(0, 6'd0, 0, tag);
  endtask

  initial begin
    rst_n = 1'b0; start = 0; strb = '0; clr = 0;
    repeat (3) @(negedge clk);
    compare("R8 reset state", '{flags: 6'd0, cnt: '0, alarm: 1'b0});
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    idle("R8 quiet after reset");
    step(1, 6'b000001, 0, "R1 parity flag, R3 first fault");
    step(0, 6'b001000, 0, "R3 second strobe same txn no increment");
    idle("R2 flags hold");
    step(1, 6'd0, 0, "R2 start clears flags");
    step(0, 6'b110000, 0, "R3 multi-bit counts once");
    step(1, 6'b000100, 0, "R2 strobe with start kept, R5 alarm rises");
    idle("R5 alarm sticky");
    step(0, 6'd0, 1, "R6 clear zeroes count and alarm, R9 flags kept");
    for (int k = 0; k < 6; k++) step(1, 6'(1 << k), 0, "R1 single bit position");
    step(1, 6'b100001, 0, "R4 reach maximum");
    step(1, 6'b000010, 0, "R4 saturate");
    step(1, 6'b001000, 0, "R4 stays saturated");
    step(1, 6'b000100, 1, "R7 clear collides with fault");
    step(1, 6'b000001, 0, "R7 count after restart");
    step(1, 6'b000001, 0, "R5 alarm after restart");
    idle("R5 hold");
    @(negedge clk);

    // Asynchronous reset asserted between edges.
    #2 rst_n = 1'b0;
    #1 compare("R8 async reset", '{flags: 6'd0, cnt: '0, alarm: 1'b0});
    m_flags = '0; m_cnt = 0; m_alarm = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    step(0, 6'b010000, 0, "R1 tx parity after reset");
    idle("R8 clean restart");
    repeat (3) @(negedge clk);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", fails, checks);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Result: errors=%0d of %0d checks", fails, checks);
      $finish;
    end
  end
endmodule